// File: doc/BRIEF.md
# MSI Forwarding Scanner

This block turns the pending and enabled state of an interrupt domain's sources into message-signalled interrupts. Whenever the surrounding register logic reports that a register write has completed, the scanner sweeps the sources from index 1 up to the last one, in ascending order. Each source that is both pending and enabled, while the domain enable is set, has its pending bit cleared through a one-cycle clear strobe. The same cycle loads one message into a valid/ready output stage. The message's hart index, guest index and interrupt identity are decoded from that source's target word.

The block keeps the per-source target words, and it masks away their reserved bit when they are written. It also holds the software message register. Writing that register stores the value with its guest field cleared and queues a single message to the written hart, with guest index 0. That message goes out ahead of the next scanned source. The pending and enable bits themselves live outside the block, which sees them as two vectors and clears pending bits through the strobe vector.

Top module: `msi_fwd_scanner`

## Requirements
- R1: While `dom_en` is 0 no scan runs, `pend_clr` stays all zero and no scanned message is emitted, whatever `wr_evt` does.
- R2: After a `wr_evt` pulse with `dom_en` set, sources are visited in ascending index order from 1 to NUM_SRC-1, and one message is emitted for each source whose `src_pend` and `src_en` bits are both 1.
- R3: Source 0 is never cleared and never sent. Target writes to index 0 or to an index at or above NUM_SRC change no stored word, and reads of such indices return 0.
- R4: A target write stores the data with bit 11 forced to 0 (mask 0xFFFFF7FF). Reads return the stored word.
- R5: A message carries hart index = target[31:18], guest index = target[17:12] and identity = target[10:0], taken from the word stored when the source's pending bit was cleared.
- R6: `pend_clr` has at most one bit set. It is set for a source in exactly the cycle that source's message is loaded, so `msi_valid` is 1 in the following cycle.
- R7: While `msi_valid` is 1 and `msi_ready` is 0, the message fields hold steady and the sweep stalls on the current source.
- R8: A `wr_evt` pulse during a sweep makes the sweep restart at source 1 once the current source has been handled.
- R9: `gen_wr` stores `gen_wr_data` with bits 17:12 cleared into `gen_q`. It emits one message with hart = data[31:18], guest = 0 and identity = data[10:0], regardless of `dom_en`.
- R10: A queued software message leaves before the next scanned source's message.
- R11: `busy` is 1 from the cycle after a sweep starts until its last source is handled, and 0 when idle and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_en | input | 1 | Domain interrupt enable |
| wr_evt | input | 1 | One-cycle pulse: a register write completed |
| src_pend | input | NUM_SRC | Pending bit per source |
| src_en | input | NUM_SRC | Enable bit per source |
| pend_clr | output | NUM_SRC | One-cycle pending clear strobe per source |
| tgt_wr | input | 1 | Target word write strobe |
| tgt_wr_idx | input | IDX_W | Source index of the target write |
| tgt_wr_data | input | 32 | Target write data |
| tgt_rd_idx | input | IDX_W | Source index of the target read |
| tgt_rd_data | output | 32 | Stored target word (combinational) |
| gen_wr | input | 1 | Software message register write strobe |
| gen_wr_data | input | 32 | Software message register write data |
| gen_q | output | 32 | Stored software message register |
| msi_valid | output | 1 | Message valid |
| msi_ready | input | 1 | Message accepted by the sink |
| msi_hart | output | 14 | Message hart index |
| msi_guest | output | 6 | Message guest index |
| msi_eiid | output | 11 | Message interrupt identity |
| busy | output | 1 | Sweep in progress |

## Verification
The bench builds the block with NUM_SRC = 20. The index ports are then 5 bits wide, so indices 20 to 31 can be driven, and the out-of-range target writes of R3 can be exercised. Twenty sources keep each sweep short, so random rounds can cover many mixes of pending and enable bits, and of sink readiness that is steady or random. The same size also makes the last source, index 19, easy to hit at the end of a sweep. Directed cases hold the sink not ready to pin the stall, the restart and the software-message priority at known sources.

// File: rtl/msi_fwd_pkg.sv
package msi_fwd_pkg;
   localparam int WORD_W    = 32;
   localparam int HART_LSB  = 18;
   localparam int HART_W    = 14;
   localparam int GUEST_LSB = 12;
   localparam int GUEST_W   = 6;
   localparam int EIID_W    = 11;
   localparam logic [WORD_W-1:0] GUEST_MASK = {{(WORD_W-GUEST_LSB-GUEST_W){1'b0}}, {GUEST_W{1'b1}}, {GUEST_LSB{1'b0}}};
   localparam logic [WORD_W-1:0] TGT_KEEP   = ~(32'h1 << EIID_W);

   typedef struct packed {
      logic [HART_W-1:0]  hart;
      logic [GUEST_W-1:0] guest;
      logic [EIID_W-1:0]  eiid;
   } msi_msg_t;

   function automatic msi_msg_t split_word(input logic [WORD_W-1:0] w);
      msi_msg_t m;
      m.hart  = w[HART_LSB +: HART_W];
      m.guest = w[GUEST_LSB +: GUEST_W];
      m.eiid  = w[EIID_W-1:0];
      return m;
   endfunction
endpackage

// File: rtl/msi_tgt_table.sv
module msi_tgt_table
   import msi_fwd_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int IDX_W   = $clog2(NUM_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data,
   input  logic [IDX_W-1:0]  scan_idx,
   output logic [WORD_W-1:0] scan_word
);
   logic [NUM_SRC*WORD_W-1:0] flat;

   for (genvar r = 0; r < NUM_SRC; r++) begin : g_row
      if (r == 0) begin : g_none
         assign flat[0 +: WORD_W] = '0;
      end else begin : g_live
         logic [WORD_W-1:0] row_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               row_q <= '0;
            else if (wr && (int'(wr_idx) == r))
               row_q <= wr_data & TGT_KEEP;
         end
         assign flat[r*WORD_W +: WORD_W] = row_q;
      end
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_idx) < NUM_SRC)
         rd_data = flat[int'(rd_idx)*WORD_W +: WORD_W];
   end

   always_comb begin
      scan_word = '0;
      if (int'(scan_idx) < NUM_SRC)
         scan_word = flat[int'(scan_idx)*WORD_W +: WORD_W];
   end
endmodule

// File: rtl/msi_sweep_ctrl.sv
module msi_sweep_ctrl
   import msi_fwd_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int IDX_W   = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dom_en,
   input  logic               wr_evt,
   input  logic [NUM_SRC-1:0] src_pend,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               gen_wr,
   input  logic [WORD_W-1:0]  gen_wr_data,
   input  logic               out_free,
   output logic [IDX_W-1:0]   scan_idx,
   output logic               take_src,
   output logic               take_gen,
   output logic [NUM_SRC-1:0] pend_clr,
   output logic [WORD_W-1:0]  gen_q,
   output logic               busy
);
   localparam logic [IDX_W-1:0] LAST  = IDX_W'(NUM_SRC - 1);
   localparam logic [IDX_W-1:0] FIRST = IDX_W'(1);

   logic             scan_on, restart, gen_req, cur_hit, step;
   logic [IDX_W-1:0] idx;

   assign cur_hit  = scan_on & dom_en & src_pend[idx] & src_en[idx];
   assign take_gen = gen_req & out_free;
   assign take_src = cur_hit & out_free & ~gen_req;
   assign step     = scan_on & dom_en & (~cur_hit | take_src);
   assign scan_idx = idx;
   assign busy     = scan_on;

   always_comb begin
      pend_clr = '0;
      if (take_src)
         pend_clr[idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_q   <= '0;
         gen_req <= 1'b0;
      end else if (gen_wr) begin
         gen_q   <= gen_wr_data & ~GUEST_MASK;
         gen_req <= 1'b1;
      end else if (take_gen) begin
         gen_req <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scan_on <= 1'b0;
         restart <= 1'b0;
         idx     <= FIRST;
      end else if (!dom_en) begin
         scan_on <= 1'b0;
         restart <= 1'b0;
      end else if (!scan_on) begin
         if (wr_evt) begin
            scan_on <= 1'b1;
            restart <= 1'b0;
            idx     <= FIRST;
         end
      end else if (step) begin
         if (restart || wr_evt) begin
            idx     <= FIRST;
            restart <= 1'b0;
         end else if (idx == LAST) begin
            scan_on <= 1'b0;
         end else begin
            idx <= idx + 1'b1;
         end
      end else if (wr_evt) begin
         restart <= 1'b1;
      end
   end
endmodule

// File: rtl/msi_out_stage.sv
module msi_out_stage
   import msi_fwd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_src,
   input  logic [WORD_W-1:0] src_word,
   input  logic              take_gen,
   input  logic [WORD_W-1:0] gen_word,
   input  logic              ready,
   output logic              valid,
   output msi_msg_t          msg
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         msg   <= '0;
      end else begin
         if (valid && ready)
            valid <= 1'b0;
         if (take_gen || take_src) begin
            valid <= 1'b1;
            msg   <= split_word(take_gen ? gen_word : src_word);
         end
      end
   end
endmodule

// File: rtl/msi_fwd_scanner.sv
module msi_fwd_scanner
   import msi_fwd_pkg::*;
#(
   parameter int NUM_SRC = 32,
   localparam int IDX_W  = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dom_en,
   input  logic               wr_evt,
   input  logic [NUM_SRC-1:0] src_pend,
   input  logic [NUM_SRC-1:0] src_en,
   output logic [NUM_SRC-1:0] pend_clr,
   input  logic               tgt_wr,
   input  logic [IDX_W-1:0]   tgt_wr_idx,
   input  logic [31:0]        tgt_wr_data,
   input  logic [IDX_W-1:0]   tgt_rd_idx,
   output logic [31:0]        tgt_rd_data,
   input  logic               gen_wr,
   input  logic [31:0]        gen_wr_data,
   output logic [31:0]        gen_q,
   output logic               msi_valid,
   input  logic               msi_ready,
   output logic [13:0]        msi_hart,
   output logic [5:0]         msi_guest,
   output logic [10:0]        msi_eiid,
   output logic               busy
);
   if (NUM_SRC < 2 || NUM_SRC > 1024) begin : g_bad_size
      $error("msi_fwd_scanner: NUM_SRC must lie in 2..1024");
   end

   logic [IDX_W-1:0]  scan_idx;
   logic [WORD_W-1:0] scan_word;
   logic              take_src, take_gen;
   msi_msg_t          msg;

   msi_tgt_table #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr(tgt_wr), .wr_idx(tgt_wr_idx), .wr_data(tgt_wr_data),
      .rd_idx(tgt_rd_idx), .rd_data(tgt_rd_data),
      .scan_idx(scan_idx), .scan_word(scan_word)
   );

   msi_sweep_ctrl #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .wr_evt(wr_evt),
      .src_pend(src_pend), .src_en(src_en),
      .gen_wr(gen_wr), .gen_wr_data(gen_wr_data), .out_free(~msi_valid),
      .scan_idx(scan_idx), .take_src(take_src), .take_gen(take_gen),
      .pend_clr(pend_clr), .gen_q(gen_q), .busy(busy)
   );

   msi_out_stage u_out (
      .clk(clk), .rst_n(rst_n),
      .take_src(take_src), .src_word(scan_word),
      .take_gen(take_gen), .gen_word(gen_q),
      .ready(msi_ready), .valid(msi_valid), .msg(msg)
   );

   assign msi_hart  = msg.hart;
   assign msi_guest = msg.guest;
   assign msi_eiid  = msg.eiid;
endmodule

// File: rtl/msi_fwd_scanner_chk.sv
module msi_fwd_scanner_chk #(
   parameter int NUM_SRC = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dom_en,
   input logic [NUM_SRC-1:0] pend_clr,
   input logic               gen_wr,
   input logic [31:0]        gen_q,
   input logic               msi_valid,
   input logic               msi_ready,
   input logic [13:0]        msi_hart,
   input logic [5:0]         msi_guest,
   input logic [10:0]        msi_eiid,
   input logic               busy
);
   a_r6_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pend_clr));

   a_r3_src0_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_clr[0]);

   a_r1_off_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !dom_en |-> (pend_clr == '0));

   a_r6_clear_loads_msg: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend_clr) |=> msi_valid);

   a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_hart)
                                     && $stable(msi_guest) && $stable(msi_eiid)));

   a_r9_gen_guest_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      gen_wr |=> (gen_q[17:12] == 6'd0));

   a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !dom_en |=> !busy);
endmodule

bind msi_fwd_scanner msi_fwd_scanner_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .pend_clr(pend_clr),
   .gen_wr(gen_wr), .gen_q(gen_q), .msi_valid(msi_valid), .msi_ready(msi_ready),
   .msi_hart(msi_hart), .msi_guest(msi_guest), .msi_eiid(msi_eiid), .busy(busy)
);

// File: tb/msi_fwd_scanner_test.sv
`timescale 1ns/1ps
module msi_fwd_scanner_test;
   localparam int NS = 20;
   localparam int IW = 5;
   localparam logic [31:0] KEEP = 32'hFFFF_F7FF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dom_en = 1'b0, wr_evt = 1'b0;
   logic [NS-1:0] pend_q = '0, en_q = '0, pend_clr;
   logic [NS-1:0] pend_set = '0, pend_val = '0;
   logic          pend_load = 1'b0;
   logic          tgt_wr = 1'b0;
   logic [IW-1:0] tgt_wr_idx = '0, tgt_rd_idx = '0;
   logic [31:0]   tgt_wr_data = '0, tgt_rd_data;
   logic          gen_wr = 1'b0;
   logic [31:0]   gen_wr_data = '0, gen_q;
   logic          msi_valid, msi_ready = 1'b0, busy;
   logic [13:0]   msi_hart;
   logic [5:0]    msi_guest;
   logic [10:0]   msi_eiid;

   int checks = 0, errors = 0;
   int rdy_mode = 1;
   logic [31:0] tgt_m [NS];
   logic [31:0] rec [64];
   logic [31:0] expv [64];
   int rec_n = 0, exp_n = 0;

   msi_fwd_scanner #(.NUM_SRC(NS)) uut (
      .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .wr_evt(wr_evt),
      .src_pend(pend_q), .src_en(en_q), .pend_clr(pend_clr),
      .tgt_wr(tgt_wr), .tgt_wr_idx(tgt_wr_idx), .tgt_wr_data(tgt_wr_data),
      .tgt_rd_idx(tgt_rd_idx), .tgt_rd_data(tgt_rd_data),
      .gen_wr(gen_wr), .gen_wr_data(gen_wr_data), .gen_q(gen_q),
      .msi_valid(msi_valid), .msi_ready(msi_ready),
      .msi_hart(msi_hart), .msi_guest(msi_guest), .msi_eiid(msi_eiid), .busy(busy)
   );

   always #10 clk = ~clk;

   // External pending state: cleared by the strobe, set or loaded by the bench.
   always @(posedge clk) begin
      if (pend_load) pend_q <= pend_val;
      else           pend_q <= (pend_q & ~pend_clr) | pend_set;
   end

   // Sink: choose readiness, then log the message that transfers at the next edge.
   always @(negedge clk) begin
      case (rdy_mode)
         0:       msi_ready = 1'b0;
         1:       msi_ready = 1'b1;
         default: msi_ready = $urandom_range(0, 1) == 1;
      endcase
      if (msi_valid && msi_ready && rec_n < 64) begin
         rec[rec_n] = {msi_hart, msi_guest, 1'b0, msi_eiid};
         rec_n++;
      end
   end

   function automatic logic [31:0] msg_of(input logic [31:0] t);
      return t & KEEP;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_tgt(input int idx, input logic [31:0] d);
      @(negedge clk);
      tgt_wr = 1'b1; tgt_wr_idx = IW'(idx); tgt_wr_data = d;
      @(negedge clk);
      tgt_wr = 1'b0;
      if (idx >= 1 && idx < NS) tgt_m[idx] = d & KEEP;
   endtask

   task automatic load_pend(input logic [NS-1:0] v);
      @(negedge clk); pend_load = 1'b1; pend_val = v;
      @(negedge clk); pend_load = 1'b0;
   endtask

   task automatic add_pend(input logic [NS-1:0] v);
      @(negedge clk); pend_set = v;
      @(negedge clk); pend_set = '0;
   endtask

   task automatic pulse_wr;
      @(negedge clk); wr_evt = 1'b1;
      @(negedge clk); wr_evt = 1'b0;
   endtask

   task automatic wait_idle;
      int quiet = 0;
      while (quiet < 4) begin
         @(negedge clk);
         if (!busy && !msi_valid) quiet++; else quiet = 0;
      end
   endtask

   task automatic compare_list(input string tag);
      chk(rec_n == exp_n, {tag, " message count"}, 32'(rec_n), 32'(exp_n));
      for (int i = 0; i < exp_n && i < rec_n; i++)
         chk(rec[i] == expv[i], {tag, " message fields"}, rec[i], expv[i]);
   endtask

   // One full sweep with expectations drawn from the bench's own snapshot.
   task automatic sweep_and_check(input string tag);
      logic [NS-1:0] p0, e0, pexp;
      p0 = pend_q; e0 = en_q; pexp = p0;
      exp_n = 0;
      if (dom_en)
         for (int s = 1; s < NS; s++)
            if (p0[s] && e0[s]) begin
               expv[exp_n] = msg_of(tgt_m[s]);
               exp_n++;
               pexp[s] = 1'b0;
            end
      rec_n = 0;
      pulse_wr();
      wait_idle();
      compare_list(tag);
      chk(pend_q == pexp, {tag, " pending after sweep"}, 32'(pend_q), 32'(pexp));
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", checks);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] held;
      void'($urandom(32'h0005_EED1));
      for (int s = 0; s < NS; s++) tgt_m[s] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state (R11, R6, R4)
      tgt_rd_idx = IW'(3);
      #1;
      chk(!busy, "R11 busy after reset", 32'(busy), 0);
      chk(!msi_valid, "R6 valid after reset", 32'(msi_valid), 0);
      chk(pend_clr == '0, "R6 no clear after reset", 32'(pend_clr), 0);
      chk(tgt_rd_data == 0, "R4 target after reset", tgt_rd_data, 0);

      // Target masking (R4) and ignored indices (R3)
      write_tgt(3, 32'hFFFF_FFFF);
      tgt_rd_idx = IW'(3); #1;
      chk(tgt_rd_data == 32'hFFFF_F7FF, "R4 bit 11 masked", tgt_rd_data, 32'hFFFF_F7FF);
      write_tgt(0, 32'hFFFF_FFFF);
      tgt_rd_idx = IW'(0); #1;
      chk(tgt_rd_data == 0, "R3 index 0 reads zero", tgt_rd_data, 0);
      write_tgt(5, 32'h1234_5678);
      write_tgt(25, 32'hDEAD_BEEF);
      tgt_rd_idx = IW'(5); #1;
      chk(tgt_rd_data == (32'h1234_5678 & KEEP), "R3 out-of-range write ignored", tgt_rd_data, 32'h1234_5678 & KEEP);
      tgt_rd_idx = IW'(25); #1;
      chk(tgt_rd_data == 0, "R3 out-of-range read zero", tgt_rd_data, 0);

      for (int s = 0; s < NS; s++) write_tgt(s, $urandom);

      // Domain disabled (R1)
      dom_en = 1'b0; en_q = '1; rdy_mode = 1;
      load_pend('1);
      sweep_and_check("R1 domain off");
      chk(!busy, "R1 no sweep while off", 32'(busy), 0);

      // Directed ordering incl. last source and source 0 (R2, R3, R5, R6)
      dom_en = 1'b1;
      en_q = NS'((1 << 0) | (1 << 4) | (1 << 7) | (1 << 9) | (1 << 19));
      load_pend(NS'((1 << 0) | (1 << 4) | (1 << 7) | (1 << 12) | (1 << 19)));
      sweep_and_check("R2 R5 R3 ordered sweep");

      // Stall and restart (R7, R8, R11)
      en_q = '1; rdy_mode = 0;
      load_pend(NS'((1 << 2) | (1 << 5)));
      rec_n = 0;
      pulse_wr();
      repeat (20) @(negedge clk);
      chk(msi_valid, "R7 message held while stalled", 32'(msi_valid), 1);
      chk(busy, "R11 busy during stalled sweep", 32'(busy), 1);
      held = {msi_hart, msi_guest, 1'b0, msi_eiid};
      chk(held == msg_of(tgt_m[2]), "R5 R7 stalled message is source 2", held, msg_of(tgt_m[2]));
      repeat (5) @(negedge clk);
      chk({msi_hart, msi_guest, 1'b0, msi_eiid} == held, "R7 fields stable", {msi_hart, msi_guest, 1'b0, msi_eiid}, held);
      add_pend(NS'(1 << 1));
      pulse_wr();
      rdy_mode = 1;
      wait_idle();
      exp_n = 3;
      expv[0] = msg_of(tgt_m[2]); expv[1] = msg_of(tgt_m[5]); expv[2] = msg_of(tgt_m[1]);
      compare_list("R8 restart order");

      // Software message alone, domain off (R9)
      dom_en = 1'b0; rec_n = 0;
      @(negedge clk); gen_wr = 1'b1; gen_wr_data = 32'hABCD_E7FF;
      @(negedge clk); gen_wr = 1'b0;
      chk(gen_q == (32'hABCD_E7FF & ~32'h0003_F000), "R9 stored guest cleared", gen_q, 32'hABCD_E7FF & ~32'h0003_F000);
      wait_idle();
      exp_n = 1; expv[0] = 32'hABCC_07FF;
      compare_list("R9 software message");

      // Software message ahead of next scanned source (R10)
      dom_en = 1'b1; rdy_mode = 0;
      load_pend(NS'((1 << 3) | (1 << 4)));
      rec_n = 0;
      pulse_wr();
      repeat (10) @(negedge clk);
      @(negedge clk); gen_wr = 1'b1; gen_wr_data = 32'h0004_5123;
      @(negedge clk); gen_wr = 1'b0;
      repeat (3) @(negedge clk);
      rdy_mode = 1;
      wait_idle();
      exp_n = 3;
      expv[0] = msg_of(tgt_m[3]); expv[1] = 32'h0004_0123; expv[2] = msg_of(tgt_m[4]);
      compare_list("R10 priority order");

      // Random rounds (R2, R5, R6, R7)
      for (int k = 0; k < 30; k++) begin
         for (int s = 1; s < NS; s++)
            if ($urandom_range(0, 3) == 0) write_tgt(s, $urandom);
         en_q = NS'($urandom);
         rdy_mode = $urandom_range(1, 2);
         load_pend(NS'($urandom));
         sweep_and_check("R2 R6 random sweep");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule